// File: doc/BRIEF.md
# NAND Flash Command and Data Front-End

This block sits between a simple memory-mapped register port and an 8-bit raw NAND flash bus. The host writes command bytes, address bytes, write-data bytes and single-byte read requests into a four-entry queue. A sequencer drains the queue one entry at a time and turns each entry into one bus cycle. Command cycles raise the command latch and address cycles raise the address latch. Every cycle has a write or read strobe whose low time is set by a programmable delay. The chip enable stays asserted while there is work pending.

Single-byte reads use a request-then-collect handshake. The host posts a read request, waits for a sticky read-ready flag, takes the byte from a read-data register, and clears the flag by writing a one to it. A page-control register starts a whole-page read or a whole-page write of 256 or 512 bytes, chosen by the control register. A page-done flag reports the end of the page. A running byte parity accumulator covers every data byte moved in either direction. Writing to the ECC-reset register clears it before each page. Status flags are combined with an interrupt mask to form one interrupt line. One status flag follows the flash ready/busy pin.

The sequencer has four states. `SEQ_IDLE` waits for work. `SEQ_SETUP` drives the latch lines and data with both strobes high. `SEQ_STROBE` holds one strobe low. `SEQ_HOLD` returns the strobe high and reports completion. Its transitions are:
- `SEQ_IDLE` to `SEQ_SETUP` when a queue entry or a page-read byte is pending.
- `SEQ_SETUP` to `SEQ_STROBE` always.
- `SEQ_STROBE` to `SEQ_HOLD` when the delay count reaches zero.
- `SEQ_HOLD` to `SEQ_IDLE` always.

Top module: `nand_front`

Register map (4-bit address, 16-bit host data):

| Addr | Name | Access | Layout |
|------|------|--------|--------|
| 0 | CTRL | read/write | [0] page size (0 = 256 bytes, 1 = 512 bytes), [1] bus-width select (stored only), [5:2] read delay, [9:6] write delay |
| 1 | STAT | read | [0] queue full, [1] queue empty, [2] page operation active |
| 2 | ISTAT | read, write-1-to-clear | [0] flash ready, live, [1] read byte ready, [2] page done |
| 3 | IMASK | read/write | [2:0] enable for each ISTAT bit |
| 4 | CMD | write | queue a command byte |
| 5 | ADDR | write | queue an address byte |
| 6 | WDATA | write | queue a write-data byte |
| 7 | RREQ | write | queue a read request (value ignored) |
| 8 | RDATA | read | last byte read from the flash |
| 9 | PGCTL | write | 1 = page read, 2 = page write |
| 10 | ECCRST | write | clear the parity accumulator |
| 11 | ECC | read | parity accumulator |

## Requirements
- R1: Queued entries leave in first-in, first-out order. The queue holds 4 entries. STAT[0] reads 1 while all 4 are held. A write to CMD, ADDR, WDATA or RREQ while the queue is full is dropped.
- R2: A CMD write produces one bus cycle with cle=1, ale=0, dq_oe=1 and dq_out equal to the byte. we_n is low for 1 plus CTRL[9:6] clock cycles.
- R3: An ADDR write produces one bus cycle with ale=1, cle=0 and dq_out equal to the byte. we_n is low for 1 plus CTRL[9:6] cycles.
- R4: A WDATA write produces one bus cycle with cle=0, ale=0 and the byte driven on dq_out, with the same we_n pulse width.
- R5: An RREQ write produces one cycle with re_n low for 1 plus CTRL[5:2] cycles and dq_oe=0. The byte on dq_in in the last low cycle is stored in RDATA, and ISTAT[1] then reads 1.
- R6: ISTAT[1] and ISTAT[2] clear only when a 1 is written to their own bit. Writing 0 leaves them set.
- R7: ISTAT[0] equals the rb_n pin two clock edges after the pin changes. Writes to ISTAT do not change it.
- R8: Writing 1 to PGCTL runs exactly 256 or 512 read cycles, as set by CTRL[0]. STAT[2] reads 1 while they run. ISTAT[2] reads 1 after the last one. Page reads do not set ISTAT[1].
- R9: Writing 2 to PGCTL makes the next 256 or 512 WDATA bytes form the page. ISTAT[2] reads 1 after the last one is driven, and STAT[2] then returns to 0.
- R10: ECC holds the XOR of every data byte written or read since the last ECCRST write. Command and address bytes are not included.
- R11: ce_n is low from the first queued entry until the queue is empty, the sequencer is idle and no page operation is active. ce_n is high after reset. No strobe goes low while ce_n is high.
- R12: IMASK resets to 0. irq is 1 exactly when some ISTAT bit and its IMASK bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Data driven to the flash |
| nf_dq_oe | output | 1 | Data output enable |
| nf_dq_in | input | 8 | Data from the flash |
| nf_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The bus sequencer is tried with a mixed command, address and data sequence. This shows that each entry type gets the right latch line and that the write pulse width follows the write delay. It is also tried with a lone read request under a different read delay, which separates read timing from write timing and shows the sampled byte. A back-to-back burst under a long write delay fills the queue. It shows whether the sixth write is dropped and whether order is kept. Full-page write and read runs, at both page sizes, tell a correct cycle count and parity result apart from an off-by-one page end or a parity that leaks command bytes.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_DATA = 2'd2,
        OP_READ = 2'd3
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] payload;
    } entry_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETUP  = 2'd1,
        SEQ_STROBE = 2'd2,
        SEQ_HOLD   = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        PG_NONE  = 2'd0,
        PG_READ  = 2'd1,
        PG_WRITE = 2'd2
    } page_mode_e;

    localparam logic [3:0] RA_CTRL   = 4'd0;
    localparam logic [3:0] RA_STAT   = 4'd1;
    localparam logic [3:0] RA_ISTAT  = 4'd2;
    localparam logic [3:0] RA_IMASK  = 4'd3;
    localparam logic [3:0] RA_CMD    = 4'd4;
    localparam logic [3:0] RA_ADDR   = 4'd5;
    localparam logic [3:0] RA_WDATA  = 4'd6;
    localparam logic [3:0] RA_RREQ   = 4'd7;
    localparam logic [3:0] RA_RDATA  = 4'd8;
    localparam logic [3:0] RA_PGCTL  = 4'd9;
    localparam logic [3:0] RA_ECCRST = 4'd10;
    localparam logic [3:0] RA_ECC    = 4'd11;

endpackage

// File: rtl/nfe_fifo.sv
module nfe_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign count   = cnt_q;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rd_ptr_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= din;
    end

endmodule

// File: rtl/nfe_seq.sv
module nfe_seq
    import nfe_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_valid,
    input  entry_t           entry,
    input  logic             page_rd_req,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic [DLY_W-1:0] wr_dly,
    input  logic [7:0]       dq_in,
    output logic             pop,
    output logic             busy,
    output logic             done,
    output op_e              done_op,
    output logic [7:0]       done_byte,
    output logic             done_page,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       dq_out,
    output logic             dq_oe
);
    seq_state_e       state_q, state_d;
    entry_t           cur_q;
    logic             from_page_q;
    logic [DLY_W-1:0] cnt_q;
    logic [7:0]       cap_q;
    logic             is_read;

    assign is_read = (cur_q.op == OP_READ);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (entry_valid || page_rd_req) state_d = SEQ_SETUP;
            SEQ_SETUP:  state_d = SEQ_STROBE;
            SEQ_STROBE: if (cnt_q == '0) state_d = SEQ_HOLD;
            SEQ_HOLD:   state_d = SEQ_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '{op: OP_CMD, payload: 8'h00};
            from_page_q <= 1'b0;
            cnt_q       <= '0;
            cap_q       <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (entry_valid) begin
                        cur_q       <= entry;
                        from_page_q <= 1'b0;
                    end else if (page_rd_req) begin
                        cur_q       <= '{op: OP_READ, payload: 8'h00};
                        from_page_q <= 1'b1;
                    end
                end
                SEQ_SETUP:  cnt_q <= is_read ? rd_dly : wr_dly;
                SEQ_STROBE: begin
                    if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
                    else if (is_read) cap_q <= dq_in;
                end
                SEQ_HOLD: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        pop       = (state_q == SEQ_IDLE) && entry_valid;
        busy      = (state_q != SEQ_IDLE);
        done      = (state_q == SEQ_HOLD);
        done_op   = cur_q.op;
        done_byte = is_read ? cap_q : cur_q.payload;
        done_page = from_page_q;
        cle       = busy && (cur_q.op == OP_CMD);
        ale       = busy && (cur_q.op == OP_ADDR);
        dq_oe     = busy && !is_read;
        dq_out    = cur_q.payload;
        we_n      = !((state_q == SEQ_STROBE) && !is_read);
        re_n      = !((state_q == SEQ_STROBE) && is_read);
    end

endmodule

// File: rtl/nand_front.sv
module nand_front
    import nfe_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int DLY_W      = 4,
    parameter int PAGE_SMALL = 256,
    parameter int PAGE_LARGE = 512,
    parameter int HOST_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [HOST_W-1:0] bus_wdata,
    output logic [HOST_W-1:0] bus_rdata,
    output logic              irq,
    output logic              nf_ce_n,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [7:0]        nf_dq_out,
    output logic              nf_dq_oe,
    input  logic [7:0]        nf_dq_in,
    input  logic              nf_rb_n
);
    localparam int EW    = $bits(entry_t);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int PG_W  = $clog2(PAGE_LARGE + 1);
    localparam int CTL_W = 2 + 2 * DLY_W;

    // register write decode
    logic wr_ctrl, wr_istat, wr_imask, wr_pgctl, wr_eccrst, push;
    op_e  push_op;
    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == RA_CTRL);
        wr_istat  = bus_wr && (bus_addr == RA_ISTAT);
        wr_imask  = bus_wr && (bus_addr == RA_IMASK);
        wr_pgctl  = bus_wr && (bus_addr == RA_PGCTL);
        wr_eccrst = bus_wr && (bus_addr == RA_ECCRST);
        push      = bus_wr && (bus_addr >= RA_CMD) && (bus_addr <= RA_RREQ);
        push_op   = op_e'(bus_addr[1:0]);
    end

    // queue
    entry_t           push_entry, head;
    logic [EW-1:0]    head_bits;
    logic             q_empty, q_full, q_pop;
    logic [CNT_W-1:0] q_cnt;
    assign push_entry = '{op: push_op, payload: bus_wdata[7:0]};
    assign head       = entry_t'(head_bits);

    nfe_fifo #(.W(EW), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_entry),
        .pop(q_pop), .dout(head_bits), .empty(q_empty), .full(q_full), .count(q_cnt)
    );

    // control register
    logic             pg_sel_q, width_sel_q;
    logic [DLY_W-1:0] rd_dly_q, wr_dly_q;
    logic [2:0]       imask_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_sel_q    <= 1'b0;
            width_sel_q <= 1'b0;
            rd_dly_q    <= '0;
            wr_dly_q    <= '0;
            imask_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                pg_sel_q    <= bus_wdata[0];
                width_sel_q <= bus_wdata[1];
                rd_dly_q    <= bus_wdata[2 +: DLY_W];
                wr_dly_q    <= bus_wdata[2 + DLY_W +: DLY_W];
            end
            if (wr_imask) imask_q <= bus_wdata[2:0];
        end
    end

    // page mode
    page_mode_e    pg_mode_q;
    logic [PG_W-1:0] pg_rem_q;
    logic seq_done, seq_done_page, seq_busy, pg_count, pg_last, page_rd_req;
    op_e        seq_done_op;
    logic [7:0] seq_done_byte;

    assign pg_count = seq_done &&
                      (((pg_mode_q == PG_READ) && seq_done_page) ||
                       ((pg_mode_q == PG_WRITE) && (seq_done_op == OP_DATA)));
    assign pg_last     = pg_count && (pg_rem_q == PG_W'(1));
    assign page_rd_req = (pg_mode_q == PG_READ) && (pg_rem_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_mode_q <= PG_NONE;
            pg_rem_q  <= '0;
        end else if (wr_pgctl && (pg_mode_q == PG_NONE) &&
                     ((bus_wdata == HOST_W'(1)) || (bus_wdata == HOST_W'(2)))) begin
            pg_mode_q <= (bus_wdata == HOST_W'(1)) ? PG_READ : PG_WRITE;
            pg_rem_q  <= pg_sel_q ? PG_W'(PAGE_LARGE) : PG_W'(PAGE_SMALL);
        end else if (pg_count) begin
            pg_rem_q <= pg_rem_q - 1'b1;
            if (pg_last) pg_mode_q <= PG_NONE;
        end
    end

    // sequencer
    nfe_seq #(.DLY_W(DLY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .entry_valid(!q_empty), .entry(head),
        .page_rd_req(page_rd_req), .rd_dly(rd_dly_q), .wr_dly(wr_dly_q),
        .dq_in(nf_dq_in), .pop(q_pop), .busy(seq_busy), .done(seq_done),
        .done_op(seq_done_op), .done_byte(seq_done_byte), .done_page(seq_done_page),
        .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n),
        .dq_out(nf_dq_out), .dq_oe(nf_dq_oe)
    );

    // status flags, read data, parity
    logic       rb_s1_q, rb_s2_q, byte_rdy_q, pg_done_q, byte_set;
    logic [7:0] rdata_q, ecc_q;
    logic [2:0] istat;
    assign byte_set = seq_done && (seq_done_op == OP_READ) && !seq_done_page;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_s1_q    <= 1'b0;
            rb_s2_q    <= 1'b0;
            byte_rdy_q <= 1'b0;
            pg_done_q  <= 1'b0;
            rdata_q    <= '0;
            ecc_q      <= '0;
        end else begin
            rb_s1_q    <= nf_rb_n;
            rb_s2_q    <= rb_s1_q;
            byte_rdy_q <= byte_set | (byte_rdy_q & ~(wr_istat & bus_wdata[1]));
            pg_done_q  <= pg_last  | (pg_done_q  & ~(wr_istat & bus_wdata[2]));
            if (seq_done && (seq_done_op == OP_READ)) rdata_q <= seq_done_byte;
            if (wr_eccrst) ecc_q <= '0;
            else if (seq_done && ((seq_done_op == OP_READ) || (seq_done_op == OP_DATA)))
                ecc_q <= ecc_q ^ seq_done_byte;
        end
    end

    assign istat   = {pg_done_q, byte_rdy_q, rb_s2_q};
    assign irq     = |(istat & imask_q);
    assign nf_ce_n = !(seq_busy || !q_empty || (pg_mode_q != PG_NONE));

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CTRL:  bus_rdata = HOST_W'({wr_dly_q, rd_dly_q, width_sel_q, pg_sel_q});
            RA_STAT:  bus_rdata = HOST_W'({pg_mode_q != PG_NONE, q_empty, q_full});
            RA_ISTAT: bus_rdata = HOST_W'(istat);
            RA_IMASK: bus_rdata = HOST_W'(imask_q);
            RA_RDATA: bus_rdata = HOST_W'(rdata_q);
            RA_ECC:   bus_rdata = HOST_W'(ecc_q);
            default:  bus_rdata = '0;
        endcase
    end

    logic unused_w;
    assign unused_w = ^{q_cnt, CTL_W'(0)};

endmodule

// File: rtl/nand_front_chk.sv
module nand_front_chk #(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             cle,
    input logic             ale,
    input logic             we_n,
    input logic             re_n,
    input logic             dq_oe,
    input logic             irq,
    input logic [2:0]       imask,
    input logic [CNT_W-1:0] q_cnt
);
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CNT_W'(FIFO_DEPTH));
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    p_read_nodrive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);
    p_ce_on_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);
    p_mask_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (imask == 3'b000) |-> !irq);
endmodule

bind nand_front nand_front_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(nf_ce_n), .cle(nf_cle), .ale(nf_ale),
    .we_n(nf_we_n), .re_n(nf_re_n), .dq_oe(nf_dq_oe), .irq(irq),
    .imask(imask_q), .q_cnt(q_cnt)
);

// File: tb/nand_front_test.sv
module nand_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, ce_n, cle, ale, we_n, re_n, dq_oe;
    logic [7:0]  dq_out, dq_in;
    logic        rb_n = 1'b1;

    int tests = 0;
    int fails = 0;
    int flash_idx = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] fbyte(int i);
        return 8'((i * 7) + 3);
    endfunction
    assign dq_in = fbyte(flash_idx);
    always @(posedge re_n) flash_idx <= flash_idx + 1;

    nand_front uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .nf_ce_n(ce_n), .nf_cle(cle), .nf_ale(ale), .nf_we_n(we_n), .nf_re_n(re_n),
        .nf_dq_out(dq_out), .nf_dq_oe(dq_oe), .nf_dq_in(dq_in), .nf_rb_n(rb_n)
    );

    // bus cycle log
    logic       lg_rd  [1024];
    logic       lg_cle [1024];
    logic       lg_ale [1024];
    logic [7:0] lg_b   [1024];
    int         lg_w   [1024];
    int  lg_n = 0;
    bit  in_st = 0;
    logic c_rd, c_cle, c_ale;
    logic [7:0] c_b;
    int  c_w;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_n || !re_n) begin
                if ((we_n === 1'b0 || re_n === 1'b0) && ce_n !== 1'b0) begin
                    tests++; fails++;
                    $display("FAIL R11 strobe with ce_n=%b expected 0", ce_n);
                end
                if (!in_st) begin
                    in_st = 1; c_w = 1; c_rd = !re_n; c_cle = cle; c_ale = ale;
                    c_b = !re_n ? dq_in : dq_out;
                end else c_w++;
            end else if (in_st) begin
                in_st = 0;
                if (lg_n < 1024) begin
                    lg_rd[lg_n] = c_rd; lg_cle[lg_n] = c_cle; lg_ale[lg_n] = c_ale;
                    lg_b[lg_n] = c_b; lg_w[lg_n] = c_w;
                end
                lg_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic push_wait(input logic [3:0] a, input logic [7:0] d);
        logic [15:0] s;
        rd(4'd1, s);
        while (s[0]) rd(4'd1, s);
        wr(a, {8'h00, d});
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (ce_n !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
        chk(ce_n === 1'b1, "R11 idle timeout", ce_n, 1);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk(ce_n === 1'b1, "R11 reset ce_n", ce_n, 1);
        chk(we_n === 1'b1 && re_n === 1'b1, "R2 reset strobes", {we_n, re_n}, 3);
        chk(irq === 1'b0, "R12 reset irq", irq, 0);
        rd(4'd3, v); chk(v == 16'h0, "R12 reset IMASK", v, 0);
        rd(4'd1, v); chk(v == 16'h2, "R1 reset STAT", v, 2);
    endtask

    task automatic t_basic();
        logic [15:0] v;
        wr(4'd0, 16'h0080);            // wr_dly=2, rd_dly=0, 256-byte page
        wr(4'd10, 16'h0);
        lg_n = 0;
        wr(4'd4, 16'h0070);
        wr(4'd5, 16'h0012);
        wr(4'd6, 16'h00A5);
        wait_idle();
        chk(lg_n == 3, "R2 cycle count", lg_n, 3);
        chk(lg_cle[0] && !lg_ale[0] && !lg_rd[0] && lg_b[0] == 8'h70 && lg_w[0] == 3,
            "R2 command cycle", {lg_cle[0], lg_ale[0], lg_b[0]}, 10'h270);
        chk(!lg_cle[1] && lg_ale[1] && lg_b[1] == 8'h12 && lg_w[1] == 3,
            "R3 address cycle", {lg_cle[1], lg_ale[1], lg_b[1]}, 10'h112);
        chk(!lg_cle[2] && !lg_ale[2] && lg_b[2] == 8'hA5 && lg_w[2] == 3,
            "R4 data cycle", lg_b[2], 8'hA5);
        rd(4'd11, v); chk(v == 16'h00A5, "R10 ecc data only", v, 16'hA5);
    endtask

    task automatic t_read();
        logic [15:0] v;
        wr(4'd0, 16'h0004);            // rd_dly=1, wr_dly=0
        wr(4'd10, 16'h0);
        wr(4'd2, 16'h0006);
        lg_n = 0;
        flash_idx = 10;
        wr(4'd7, 16'h1234);
        wait_idle();
        chk(lg_n == 1 && lg_rd[0] && lg_w[0] == 2, "R5 read strobe width", lg_w[0], 2);
        rd(4'd8, v); chk(v == 16'(fbyte(10)), "R5 RDATA", v, fbyte(10));
        rd(4'd2, v); chk(v[1] == 1'b1, "R5 byte ready", v[1], 1);
        rd(4'd11, v); chk(v == 16'(fbyte(10)), "R10 ecc read byte", v, fbyte(10));
        wr(4'd2, 16'h0000);
        rd(4'd2, v); chk(v[1] == 1'b1, "R6 write 0 keeps", v[1], 1);
        wr(4'd2, 16'h0002);
        rd(4'd2, v); chk(v[1] == 1'b0, "R6 write 1 clears", v[1], 0);
    endtask

    task automatic t_full();
        logic [15:0] v;
        wr(4'd0, 16'h03C0);            // wr_dly=15
        lg_n = 0;
        @(negedge clk);
        for (int k = 1; k <= 6; k++) begin
            bus_addr = 4'd4; bus_wr = 1'b1; bus_wdata = 16'(k);
            @(negedge clk);
        end
        bus_wr = 1'b0;
        rd(4'd1, v); chk(v[0] == 1'b1, "R1 full flag", v[0], 1);
        wait_idle();
        chk(lg_n == 5, "R1 sixth write dropped", lg_n, 5);
        for (int k = 0; k < 5; k++)
            chk(lg_b[k] == 8'(k + 1) && lg_w[k] == 16, "R1 fifo order", lg_b[k], k + 1);
    endtask

    task automatic t_irq();
        wr(4'd0, 16'h0000);
        wr(4'd7, 16'h0);
        wait_idle();
        chk(irq === 1'b0, "R12 masked flag no irq", irq, 0);
        wr(4'd3, 16'h0002);
        @(negedge clk);
        chk(irq === 1'b1, "R12 irq on enabled flag", irq, 1);
        wr(4'd2, 16'h0002);
        @(negedge clk);
        chk(irq === 1'b0, "R12 irq after clear", irq, 0);
        wr(4'd3, 16'h0000);
    endtask

    task automatic t_rb();
        logic [15:0] v;
        @(negedge clk); rb_n = 1'b0;
        repeat (2) @(negedge clk);
        rd(4'd2, v); chk(v[0] == 1'b0, "R7 busy seen", v[0], 0);
        wr(4'd2, 16'h0001);
        rd(4'd2, v); chk(v[0] == 1'b0, "R7 write no effect", v[0], 0);
        rb_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(4'd2, v); chk(v[0] == 1'b1, "R7 ready seen", v[0], 1);
    endtask

    task automatic t_page_write();
        logic [15:0] v;
        logic [7:0]  e = 8'h00;
        wr(4'd0, 16'h0000);
        wr(4'd10, 16'h0);
        wr(4'd9, 16'h0002);
        rd(4'd1, v); chk(v[2] == 1'b1, "R9 page active", v[2], 1);
        chk(ce_n === 1'b0, "R11 ce held during page", ce_n, 0);
        lg_n = 0;
        push_wait(4'd4, 8'h80);        // command byte not in page or parity
        for (int i = 0; i < 256; i++) begin
            push_wait(4'd6, 8'(i) ^ 8'h5A);
            e ^= 8'(i) ^ 8'h5A;
        end
        wait_idle();
        chk(lg_n == 257, "R9 cycles", lg_n, 257);
        rd(4'd2, v); chk(v[2] == 1'b1, "R9 page done", v[2], 1);
        rd(4'd1, v); chk(v[2] == 1'b0, "R9 page inactive", v[2], 0);
        rd(4'd11, v); chk(v == 16'(e), "R10 page write parity", v, e);
        wr(4'd2, 16'h0004);
        rd(4'd2, v); chk(v[2] == 1'b0, "R6 page done clear", v[2], 0);
    endtask

    task automatic t_page_read();
        logic [15:0] v;
        logic [7:0]  e = 8'h00;
        int bad = 0;
        wr(4'd0, 16'h0005);            // 512-byte page, rd_dly=1
        wr(4'd10, 16'h0);
        wr(4'd2, 16'h0006);
        flash_idx = 0;
        lg_n = 0;
        wr(4'd9, 16'h0001);
        rd(4'd1, v); chk(v[2] == 1'b1, "R8 page busy", v[2], 1);
        wait_idle();
        for (int i = 0; i < 512; i++) e ^= fbyte(i);
        for (int i = 0; i < 512 && i < lg_n; i++)
            if (!lg_rd[i] || lg_w[i] != 2 || lg_b[i] != fbyte(i)) bad++;
        chk(lg_n == 512, "R8 read count", lg_n, 512);
        chk(bad == 0, "R8 read cycles", bad, 0);
        rd(4'd2, v); chk(v[2:1] == 2'b10, "R8 done, no byte flag", v[2:1], 2);
        rd(4'd11, v); chk(v == 16'(e), "R10 page read parity", v, e);
        rd(4'd8, v); chk(v == 16'(fbyte(511)), "R8 last byte", v, fbyte(511));
    endtask

    bit finished = 0;
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_read();
        t_full();
        t_irq();
        t_rb();
        t_page_write();
        t_page_read();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule